// File: doc/BRIEF.md
# Infrared Frame Serializer with Underrun Abort

This block turns a byte stream into a medium-rate infrared frame, one bit at a time. Bytes arrive on a valid/ready interface, and `in_last` marks the final byte of a frame. The first byte of a frame is the address. Any optional control byte and the payload bytes follow it in order. The transmitter wraps these bytes in the following sequence:

- an opening flag;
- the bytes, with zero insertion;
- the ones-complement of a 16-bit CCITT CRC that the block computes itself;
- a closing flag.

The output is a serial stream of bits with a strobe, and it feeds the RZ-inverted modulator downstream. The strobe rate is set by `bit_tick`, an enable pulse with one pulse per bit period.

**Back-pressure rules.** `in_ready` rises only on a `bit_tick` cycle where the serializer needs the next byte. A byte moves only in a cycle where both `in_valid` and `in_ready` are high. Once the source raises `in_valid`, it must hold `in_valid` high and `in_data`/`in_last` stable until that transfer happens. The source may drop `in_valid` freely after a transfer.

**Underrun behaviour.** A frame is open once its address has been taken. If the source has no byte ready when the serializer reaches a byte boundary inside an open frame, the frame is aborted. The block then pulses an interrupt, sends a run of ones, reports the frame as aborted, and goes back to idle.

Top module: `irtx_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `ser_bit` is 1 and `in_ready` is 0. Every strobed bit sent while idle is 1.
- R2: Each cycle with `bit_tick` high yields exactly one bit. `ser_stb` is high in the following cycle, and no `ser_stb` occurs otherwise.
- R3: A frame starts on a tick where the block is idle and `in_valid` is high. That tick still sends a 1. The next eight strobes carry the flag 0x7E, least significant bit first (0,1,1,1,1,1,1,0), with no zero insertion.
- R4: Each byte is accepted only on a tick at a byte boundary, exactly once. Its bits are sent LSB first. The first accepted byte is the address, and the byte carrying `in_last`=1 is the last data byte. No byte is accepted from then until the frame ends.
- R5: From the first data bit through the last CRC bit, a 0 is inserted after every five consecutive 1s. This includes a run of five that ends just before the closing flag or an abort. While the 0 is inserted, no byte is accepted.
- R6: The CRC uses the reflected polynomial 0x8408, starts at 0xFFFF, and is updated over every data bit (inserted zeros excluded). Its ones-complement follows the data as 16 bits: bit 0 first, so the low byte goes first.
- R7: The closing flag 0x7E follows the CRC, LSB first. `done_stb` is high together with the strobe of its last bit, and `done_abort` is 0 at that point.
- R8: If `in_valid` is low at a byte boundary of an open frame, the block sends `ABORT_ONES` ones (default 7) and then idles. `underrun_irq` pulses with the strobe of the first of these ones. `done_stb` and `done_abort`=1 come with the strobe of the last one.
- R9: `in_data` and `in_last` are taken only in a cycle where `in_valid` and `in_ready` are both high. A byte that is held while `in_ready` is low is sent exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle enable, one pulse per output bit |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready (only on a tick at a byte boundary) |
| in_data | input | 8 | Byte to send, LSB transmitted first |
| in_last | input | 1 | Marks the final data byte of a frame |
| ser_bit | output | 1 | Serial bit to the modulator; 1 means no pulse |
| ser_stb | output | 1 | High for one cycle when `ser_bit` carries a new bit |
| done_stb | output | 1 | Frame finished, with the strobe of its last bit |
| done_abort | output | 1 | Qualifies `done_stb`: frame was aborted by underrun |
| underrun_irq | output | 1 | One-cycle interrupt pulse when an underrun abort starts |

## Verification
The checker assumes that the source honours the hold rule. Once `in_valid` is high without `in_ready`, it stays high with unchanged data in the next cycle. The bench keeps to this: it raises `in_valid` only with a byte it will hold, and drops it only in the cycle after a transfer. That is also how it creates underruns at a chosen byte count. `bit_tick` carries no assumption, and the bench paces it at one, two and three cycles per bit so that ticks land both with and without idle cycles between them.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W = 16;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [FCS_W-1:0] FCS_POLY_REFL = 16'h8408;
  localparam logic [FCS_W-1:0] FCS_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFLAG,
    ST_DATA,
    ST_FCS,
    ST_CFLAG,
    ST_ABORT
  } irtx_state_e;

  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? FCS_POLY_REFL : '0);
  endfunction
endpackage

// File: rtl/irtx_crc16.sv
module irtx_crc16
  import irtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [FCS_W-1:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= FCS_PRESET;
    else if (clr) crc_q <= FCS_PRESET;
    else if (en)  crc_q <= fcs_step(crc_q, din);
  end
endmodule

// File: rtl/irtx_fsm.sv
module irtx_fsm
  import irtx_pkg::*;
#(
  parameter int ABORT_ONES = 7,
  parameter int STUFF_RUN  = 5,
  parameter int CNT_W      = 5,
  parameter int RUN_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [FCS_W-1:0]  crc_q,
  output logic              crc_clr,
  output logic              crc_en,
  output logic              crc_din,
  output logic              bit_c,
  output logic              pay_c,
  output logic              done_c,
  output logic              abort_c,
  output logic              irq_c
);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_FCS  = CNT_W'(FCS_W - 1);
  localparam logic [CNT_W-1:0] LAST_ABRT = CNT_W'(ABORT_ONES - 1);
  localparam logic [RUN_W-1:0] RUN_LIM   = RUN_W'(STUFF_RUN);

  irtx_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [RUN_W-1:0]  ones_q, ones_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              last_q, last_d;
  logic              stuff_zone, stuff_now, take;

  assign stuff_zone = (state_q == ST_DATA) || (state_q == ST_FCS) ||
                      ((state_q == ST_CFLAG) && (cnt_q == '0));
  assign stuff_now  = stuff_zone && (ones_q == RUN_LIM);
  assign in_ready   = bit_tick && (state_q == ST_DATA) && (cnt_q == '0) && !stuff_now;
  assign take       = in_ready && in_valid;
  assign crc_din    = bit_c;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ones_d  = ones_q;
    sh_d    = sh_q;
    last_d  = last_q;
    bit_c   = 1'b1;
    pay_c   = 1'b0;
    done_c  = 1'b0;
    abort_c = 1'b0;
    irq_c   = 1'b0;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    if (bit_tick) begin
      if (stuff_now) begin
        bit_c  = 1'b0;
        pay_c  = 1'b1;
        ones_d = '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (in_valid) begin
              state_d = ST_OFLAG;
              cnt_d   = '0;
              crc_clr = 1'b1;
            end
          end
          ST_OFLAG: begin
            bit_c = FLAG_BYTE[cnt_q[2:0]];
            if (cnt_q == LAST_BIT) begin
              state_d = ST_DATA;
              cnt_d   = '0;
              ones_d  = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == '0) begin
              if (take) begin
                bit_c  = in_data[0];
                sh_d   = in_data;
                last_d = in_last;
                cnt_d  = CNT_W'(1);
                pay_c  = 1'b1;
                crc_en = 1'b1;
              end else begin
                state_d = ST_ABORT;
                cnt_d   = CNT_W'(1);
                irq_c   = 1'b1;
              end
            end else begin
              bit_c  = sh_q[cnt_q[2:0]];
              pay_c  = 1'b1;
              crc_en = 1'b1;
              if (cnt_q == LAST_BIT) begin
                cnt_d = '0;
                if (last_q) state_d = ST_FCS;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
          end
          ST_FCS: begin
            bit_c = ~crc_q[cnt_q[3:0]];
            pay_c = 1'b1;
            if (cnt_q == LAST_FCS) begin
              state_d = ST_CFLAG;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          ST_CFLAG: begin
            bit_c = FLAG_BYTE[cnt_q[2:0]];
            if (cnt_q == LAST_BIT) begin
              state_d = ST_IDLE;
              done_c  = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          ST_ABORT: begin
            if (cnt_q == LAST_ABRT) begin
              state_d = ST_IDLE;
              done_c  = 1'b1;
              abort_c = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: state_d = ST_IDLE;
        endcase
        if (pay_c) ones_d = bit_c ? ones_q + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ones_q  <= '0;
      sh_q    <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ones_q  <= ones_d;
      sh_q    <= sh_d;
      last_q  <= last_d;
    end
  end
endmodule

// File: rtl/irtx_serout.sv
module irtx_serout (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic bit_c,
  input  logic pay_c,
  input  logic done_c,
  input  logic abort_c,
  input  logic irq_c,
  output logic ser_bit,
  output logic ser_stb,
  output logic pay_q,
  output logic done_stb,
  output logic done_abort,
  output logic underrun_irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_bit      <= 1'b1;
      ser_stb      <= 1'b0;
      pay_q        <= 1'b0;
      done_stb     <= 1'b0;
      done_abort   <= 1'b0;
      underrun_irq <= 1'b0;
    end else begin
      ser_stb      <= bit_tick;
      done_stb     <= bit_tick && done_c;
      done_abort   <= bit_tick && abort_c;
      underrun_irq <= bit_tick && irq_c;
      if (bit_tick) begin
        ser_bit <= bit_c;
        pay_q   <= pay_c;
      end
    end
  end
endmodule

// File: rtl/irtx_frame_tx.sv
module irtx_frame_tx
  import irtx_pkg::*;
#(
  parameter int ABORT_ONES = 7,
  parameter int STUFF_RUN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              ser_bit,
  output logic              ser_stb,
  output logic              done_stb,
  output logic              done_abort,
  output logic              underrun_irq
);
  localparam int CNT_MAX = (ABORT_ONES > FCS_W) ? ABORT_ONES : FCS_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int RUN_W   = $clog2(STUFF_RUN + 1);

  logic [FCS_W-1:0] crc_q;
  logic crc_clr, crc_en, crc_din;
  logic bit_c, pay_c, done_c, abort_c, irq_c;
  logic pay_q;

  irtx_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (crc_din),
    .crc_q (crc_q)
  );

  irtx_fsm #(
    .ABORT_ONES (ABORT_ONES),
    .STUFF_RUN  (STUFF_RUN),
    .CNT_W      (CNT_W),
    .RUN_W      (RUN_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .crc_q    (crc_q),
    .crc_clr  (crc_clr),
    .crc_en   (crc_en),
    .crc_din  (crc_din),
    .bit_c    (bit_c),
    .pay_c    (pay_c),
    .done_c   (done_c),
    .abort_c  (abort_c),
    .irq_c    (irq_c)
  );

  irtx_serout u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .bit_c        (bit_c),
    .pay_c        (pay_c),
    .done_c       (done_c),
    .abort_c      (abort_c),
    .irq_c        (irq_c),
    .ser_bit      (ser_bit),
    .ser_stb      (ser_stb),
    .pay_q        (pay_q),
    .done_stb     (done_stb),
    .done_abort   (done_abort),
    .underrun_irq (underrun_irq)
  );
endmodule

// File: rtl/irtx_frame_tx_chk.sv
module irtx_frame_tx_chk #(
  parameter int STUFF_RUN = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       ser_bit,
  input logic       ser_stb,
  input logic       pay_q,
  input logic       done_stb,
  input logic       underrun_irq
);
  logic armed;
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      run_q <= '0;
    end else begin
      armed <= 1'b1;
      if (ser_stb) run_q <= (pay_q && ser_bit) ? run_q + 1'b1 : '0;
    end
  end

  AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (ser_stb == $past(bit_tick))); // R2
  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_tick); // R4
  AST_STUFF_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_stb && pay_q && (run_q == 4'(STUFF_RUN))) |-> !ser_bit); // R5
  AST_DONE_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |-> ser_stb); // R7
  AST_IRQ_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_irq |-> (ser_stb && ser_bit && !pay_q)); // R8
  AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data))); // R9
endmodule

bind irtx_frame_tx irtx_frame_tx_chk #(.STUFF_RUN(STUFF_RUN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .ser_bit      (ser_bit),
  .ser_stb      (ser_stb),
  .pay_q        (pay_q),
  .done_stb     (done_stb),
  .underrun_irq (underrun_irq)
);

// File: tb/irtx_frame_tx_tb.sv
module irtx_frame_tx_tb;
  localparam int ABORT_ONES = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready, ser_bit, ser_stb, done_stb, done_abort, underrun_irq;

  always #2 clk = ~clk;

  irtx_frame_tx #(.ABORT_ONES(ABORT_ONES)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .ser_bit(ser_bit), .ser_stb(ser_stb), .done_stb(done_stb),
    .done_abort(done_abort), .underrun_irq(underrun_irq)
  );

  int nchk = 0, nfail = 0;
  bit cap [0:65535];
  int ncap = 0;
  bit done_seen, done_ab, irq_seen;
  int done_at, irq_at, nirq;
  bit ex [0:1023];
  int elen, run, abort_at, ph, nticks;
  logic [7:0] bytes [0:15];

  always @(posedge clk) begin
    #1;
    if (rst_n && ser_stb) begin
      cap[ncap] = ser_bit;
      ncap++;
      if (done_stb) begin done_seen = 1; done_at = ncap; done_ab = done_abort; end
      if (underrun_irq) begin irq_seen = 1; irq_at = ncap; nirq++; end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic cyc(int div);
    @(negedge clk);
    bit_tick = (ph == 0);
    if (ph == 0) nticks++;
    ph = (ph + 1 >= div) ? 0 : ph + 1;
  endtask

  task automatic add_raw(bit b);
    ex[elen] = b;
    elen++;
  endtask

  task automatic add_pay(bit b);
    add_raw(b);
    run = b ? run + 1 : 0;
    if (run == 5) begin add_raw(1'b0); run = 0; end
  endtask

  task automatic run_frame(int n, int k, int p, int div);
    logic [15:0] c;
    int base, s, idx, mism;
    bit fb;
    for (int i = 0; i < n; i++) begin
      case (p)
        0: bytes[i] = 8'hFF;
        1: bytes[i] = 8'h7E;
        2: bytes[i] = 8'((i * 37 + n * 11 + 5) & 255);
        default: bytes[i] = (i % 2 == 0) ? 8'h00 : 8'hF8;
      endcase
    end
    elen = 0; run = 0; c = 16'hFFFF; abort_at = -1;
    for (int j = 0; j < 8; j++) add_raw(j != 0 && j != 7);
    for (int i = 0; i < k; i++)
      for (int j = 0; j < 8; j++) begin
        add_pay(bytes[i][j]);
        fb = c[0] ^ bytes[i][j];
        c = (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
      end
    if (k == n) begin
      c = ~c;
      for (int j = 0; j < 16; j++) add_pay(c[j]);
      for (int j = 0; j < 8; j++) add_raw(j != 0 && j != 7);
    end else begin
      abort_at = elen;
      for (int j = 0; j < ABORT_ONES; j++) add_raw(1'b1);
    end
    base = ncap; done_seen = 0; irq_seen = 0; nirq = 0; idx = 0;
    while (1) begin
      cyc(div);
      if (done_seen) break;
      if (idx < k) begin
        in_valid = 1'b1; in_data = bytes[idx]; in_last = (idx == n - 1);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (in_valid && in_ready) idx++;
    end
    in_valid = 1'b0; in_last = 1'b0;
    repeat (6) cyc(div);
    s = base;
    while (s < ncap && cap[s] == 1'b1) s++;
    mism = 0;
    for (int i = 0; i < elen; i++) if (cap[s + i] !== ex[i]) mism++;
    chk(mism == 0, "R3 R4 R5 R6", $sformatf("bitstream n=%0d k=%0d p=%0d div=%0d mismatches", n, k, p, div), mism, 0);
    chk(idx == k, "R4 R9", "bytes accepted", idx, k);
    chk(done_at - s == elen, (k == n) ? "R7" : "R8", "done strobe position", done_at - s, elen);
    chk(done_ab == (k != n), (k == n) ? "R7" : "R8", "done_abort", done_ab, k != n);
    if (k == n) chk(nirq == 0, "R7", "interrupt count on clean frame", nirq, 0);
    else chk(irq_seen && irq_at - s == abort_at + 1, "R8", "interrupt position", irq_at - s, abort_at + 1);
    mism = 0;
    for (int i = s + elen; i < ncap; i++) if (cap[i] !== 1'b1) mism++;
    chk(mism == 0, "R1", "idle bits after frame not one", mism, 0);
  endtask

  task automatic run_all();
    int errs, base;
    ph = 0; nticks = 0;
    repeat (3) @(negedge clk);
    chk(ser_bit === 1'b1 && ser_stb === 1'b0, "R1", "reset output bit/strobe", {ser_bit, ser_stb}, 2);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(in_ready === 1'b0 && ser_bit === 1'b1, "R1", "idle after reset ready/bit", {in_ready, ser_bit}, 1);
    for (int div = 1; div <= 3; div++) begin
      errs = 0; base = ncap; nticks = 0;
      repeat (20) begin cyc(div); #1; if (in_ready !== 1'b0) errs++; end
      @(negedge clk); bit_tick = 1'b0; ph = 0;
      repeat (2) @(negedge clk);
      chk(errs == 0, "R1", "in_ready high while idle", errs, 0);
      chk(ncap - base == nticks, "R2", "strobes per ticks", ncap - base, nticks);
      errs = 0;
      for (int i = base; i < ncap; i++) if (cap[i] !== 1'b1) errs++;
      chk(errs == 0, "R1", "idle strobed zeros", errs, 0);
    end
    for (int div = 1; div <= 3; div++)
      for (int n = 1; n <= 6; n++)
        for (int p = 0; p < 4; p++) run_frame(n, n, p, div);
    for (int div = 1; div <= 3; div++)
      for (int k = 1; k <= 3; k++)
        for (int p = 0; p < 4; p++) run_frame(4, k, p, div);
  endtask

  initial begin
    bit timeout;
    timeout = 0;
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "R1", "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule